// File: doc/BRIEF.md
# Flash Controller Interrupt and Status Registers

This block is the register front end of a NAND-style flash controller. It holds the command register, two system-configuration registers, a controller status register carrying four error flags, and an interrupt status register. Software reaches these through a 16-bit register port. A command write that the block accepts produces a one-cycle strobe toward a separate command engine. That engine later reports completion or failure with an event pulse, and the block folds the pulse into the status and interrupt registers.

One interrupt line leaves the block, and a configuration bit selects its polarity. The interrupt register is cleared by writing a mask that is ANDed in. When such a write drops the pending bit, the error flags are wiped at the same time. While an interrupt is pending, command writes are refused.

A cold reset (`rst`) and a warm reset (`warm_rst`) load the same configuration and status values. They leave different completion codes in the interrupt register.

Top module: `flash_irq_regs`

## Requirements
- R1: After a cold reset: configuration-1 reads 0x40C0, configuration-2 reads 0x0000, status reads 0x0000, interrupt reads 0x8080, the command register reads 0x0000, `irq_o` is 1, `ready_o` is 1 and `cmd_strobe_o` is 0.
- R2: A warm-reset pulse loads the same values as R1, except that the interrupt register reads 0x8010.
- R3: Reading configuration-1 returns the stored value ANDed with 0xFFE0.
- R4: On every write to configuration-1, `ready_o` takes bit 7 of the written value. The change is visible after the write's clock edge.
- R5: `irq_o` equals interrupt bit 15 XOR the inverse of configuration-1 bit 6. It is registered, so it follows the causing state one cycle later.
- R6: A write to the interrupt register stores the old value ANDed with the written data.
- R7: If an interrupt write leaves bit 15 clear, status bits 10, 11, 12 and 13 are cleared. If bit 15 stays set, the status register is unchanged.
- R8: A command write while interrupt bit 15 is set has no effect. The command register keeps its value and no strobe is issued.
- R9: An accepted command write latches the value. In the same edge, `cmd_strobe_o` goes high for exactly one cycle with `cmd_code_o` equal to that value.
- R10: An event with `evt_cls_en_i` = 1 sets interrupt bit 15 and class bit 4 + `evt_cls_i`. The codes are 0 reset, 1 erase, 2 program and 3 load.
- R11: An event ORs `evt_err_i` into status bits 13..10. The error bits map as: bit 0 is command (status bit 10), bit 1 erase (11), bit 2 program (12), bit 3 load (13). An unknown command is reported as `evt_cls_en_i` = 0 with the command error bit set. It sets only interrupt bit 15 and status bit 10.
- R12: An event that arrives in the same cycle as an interrupt write is applied after the AND-clear and the error wipe, so none of its bits is lost.
- R13: The register offsets are: 0 command, 1 configuration-1, 2 configuration-2, 3 status, 4 interrupt. Other offsets read 0 and ignore writes. Read data is registered and shows the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high cold reset |
| warm_rst | input | 1 | Synchronous active-high warm reset pulse |
| reg_addr | input | 3 | Register offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |
| cmd_strobe_o | output | 1 | One-cycle start pulse to the command engine |
| cmd_code_o | output | 16 | Latched command value |
| evt_valid_i | input | 1 | Engine event pulse |
| evt_cls_i | input | 2 | Completion class of the event |
| evt_cls_en_i | input | 1 | Event carries a completion class |
| evt_err_i | input | 4 | Error flags reported with the event |
| irq_o | output | 1 | Interrupt line, polarity set by configuration-1 bit 6 |
| ready_o | output | 1 | Ready line, set from configuration-1 bit 7 |

## Verification
Register writes, engine events, `ready_o` and `cmd_strobe_o` all take effect at the clock edge that samples them. `irq_o` lags that state by one more edge. Register reads return data one edge after the address is driven. The bench drives every input on the falling edge. It samples the strobe and ready lines on the falling edge right after the write. It checks `irq_o` on that falling edge and again on the next one, to show the one-cycle lag. Each read is taken on the second falling edge after the address is set.

// File: rtl/flash_regs_pkg.sv
package flash_regs_pkg;
  localparam int DATA_W     = 16;
  localparam int SEL_W      = 3;
  localparam int NUM_CLS    = 4;
  localparam int CLS_W      = $clog2(NUM_CLS);
  localparam int CLS_LSB    = 4;
  localparam int NUM_ERR    = 4;
  localparam int ERR_LSB    = 10;
  localparam int PEND_BIT   = 15;
  localparam int POL_BIT    = 6;
  localparam int RDY_BIT    = 7;

  localparam logic [DATA_W-1:0] CFG1_INIT     = 16'h40C0;
  localparam logic [DATA_W-1:0] CFG2_INIT     = 16'h0000;
  localparam logic [DATA_W-1:0] CFG1_RD_MASK  = 16'hFFE0;
  localparam logic [DATA_W-1:0] INT_COLD_INIT = 16'h8080;
  localparam logic [DATA_W-1:0] INT_WARM_INIT = 16'h8010;

  typedef enum logic [SEL_W-1:0] {
    SEL_CMD  = 3'd0,
    SEL_CFG1 = 3'd1,
    SEL_CFG2 = 3'd2,
    SEL_STAT = 3'd3,
    SEL_INT  = 3'd4
  } reg_sel_e;

  function automatic logic [DATA_W-1:0] err_field_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int k = 0; k < NUM_ERR; k++) m[ERR_LSB+k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fc_cfg_regs.sv
module fc_cfg_regs
  import flash_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              cfg1_we,
  input  logic              cfg2_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg1_q,
  output logic [DATA_W-1:0] cfg2_q,
  output logic              ready_q
);
  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      cfg1_q  <= CFG1_INIT;
      cfg2_q  <= CFG2_INIT;
      ready_q <= 1'b1;
    end else begin
      if (cfg1_we) begin
        cfg1_q  <= wdata;
        ready_q <= wdata[RDY_BIT];
      end
      if (cfg2_we) cfg2_q <= wdata;
    end
  end

  // R4
  ready_track_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    cfg1_we |=> (ready_q == $past(wdata[RDY_BIT])));
endmodule

// File: rtl/fc_cmd_gate.sv
module fc_cmd_gate
  import flash_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              cmd_we,
  input  logic              pending,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cmd_q,
  output logic              strobe_q
);
  logic accept;
  assign accept = cmd_we && !pending;

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      cmd_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= accept;
      if (accept) cmd_q <= wdata;
    end
  end

  // R8
  cmd_refused_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (cmd_we && pending) |=> (!strobe_q && $stable(cmd_q)));
  // R9
  cmd_taken_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (cmd_we && !pending) |=> (strobe_q && cmd_q == $past(wdata)));
endmodule

// File: rtl/fc_int_status.sv
module fc_int_status
  import flash_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              warm_rst,
  input  logic              int_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_valid,
  input  logic [CLS_W-1:0]  evt_cls,
  input  logic              evt_cls_en,
  input  logic [NUM_ERR-1:0] evt_err,
  output logic [DATA_W-1:0] int_q,
  output logic [DATA_W-1:0] stat_q
);
  localparam logic [DATA_W-1:0] ERR_MASK = err_field_mask();

  logic [DATA_W-1:0] int_masked, evt_int_bits, evt_err_bits;
  logic [DATA_W-1:0] int_d, stat_kept, stat_d;
  logic              wipe;

  always_comb begin
    int_masked = int_we ? (int_q & wdata) : int_q;
    wipe       = int_we && !int_masked[PEND_BIT];
    stat_kept  = wipe ? (stat_q & ~ERR_MASK) : stat_q;
  end

  always_comb begin
    evt_int_bits = '0;
    evt_err_bits = '0;
    if (evt_valid) begin
      evt_int_bits[PEND_BIT] = 1'b1;
      for (int k = 0; k < NUM_CLS; k++) begin
        if (evt_cls_en && evt_cls == CLS_W'(k)) evt_int_bits[CLS_LSB+k] = 1'b1;
      end
      for (int e = 0; e < NUM_ERR; e++) evt_err_bits[ERR_LSB+e] = evt_err[e];
    end
  end

  assign int_d  = int_masked | evt_int_bits;
  assign stat_d = stat_kept | evt_err_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_q  <= INT_COLD_INIT;
      stat_q <= '0;
    end else if (warm_rst) begin
      int_q  <= INT_WARM_INIT;
      stat_q <= '0;
    end else begin
      int_q  <= int_d;
      stat_q <= stat_d;
    end
  end

  // R6
  int_and_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (int_we && !evt_valid) |=> (int_q == ($past(int_q) & $past(wdata))));
  // R7
  err_wipe_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (int_we && !evt_valid && !(int_q[PEND_BIT] && wdata[PEND_BIT]))
      |=> ((stat_q & ERR_MASK) == '0));
  // R10
  evt_pending_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    evt_valid |=> int_q[PEND_BIT]);
  // R11
  evt_err_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    evt_valid |=> ((stat_q[ERR_LSB +: NUM_ERR] & $past(evt_err)) == $past(evt_err)));
endmodule

// File: rtl/fc_irq_drive.sv
module fc_irq_drive
  import flash_regs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic warm_rst,
  input  logic pending,
  input  logic pol_bit,
  output logic irq_q
);
  logic seen_edge;

  always_ff @(posedge clk) begin
    if (rst || warm_rst) begin
      irq_q     <= 1'b1;
      seen_edge <= 1'b0;
    end else begin
      irq_q     <= pending ^ ~pol_bit;
      seen_edge <= 1'b1;
    end
  end

  // R5
  irq_lag_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    seen_edge |-> (irq_q == ($past(pending) ^ ~$past(pol_bit))));
endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs
  import flash_regs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               warm_rst,
  input  logic [SEL_W-1:0]   reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               cmd_strobe_o,
  output logic [DATA_W-1:0]  cmd_code_o,
  input  logic               evt_valid_i,
  input  logic [CLS_W-1:0]   evt_cls_i,
  input  logic               evt_cls_en_i,
  input  logic [NUM_ERR-1:0] evt_err_i,
  output logic               irq_o,
  output logic               ready_o
);
  logic              we_cmd, we_cfg1, we_cfg2, we_int;
  logic [DATA_W-1:0] cfg1_q, cfg2_q, int_q, stat_q, cmd_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    we_cmd  = reg_we && (reg_addr == SEL_CMD);
    we_cfg1 = reg_we && (reg_addr == SEL_CFG1);
    we_cfg2 = reg_we && (reg_addr == SEL_CFG2);
    we_int  = reg_we && (reg_addr == SEL_INT);
  end

  fc_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .cfg1_we(we_cfg1), .cfg2_we(we_cfg2), .wdata(reg_wdata),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .ready_q(ready_o)
  );

  fc_cmd_gate u_cmd (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .cmd_we(we_cmd), .pending(int_q[PEND_BIT]), .wdata(reg_wdata),
    .cmd_q(cmd_q), .strobe_q(cmd_strobe_o)
  );

  fc_int_status u_int (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .int_we(we_int), .wdata(reg_wdata),
    .evt_valid(evt_valid_i), .evt_cls(evt_cls_i), .evt_cls_en(evt_cls_en_i),
    .evt_err(evt_err_i), .int_q(int_q), .stat_q(stat_q)
  );

  fc_irq_drive u_irq (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .pending(int_q[PEND_BIT]), .pol_bit(cfg1_q[POL_BIT]), .irq_q(irq_o)
  );

  assign cmd_code_o = cmd_q;

  always_comb begin
    case (reg_addr)
      SEL_CMD:  rd_mux = cmd_q;
      SEL_CFG1: rd_mux = cfg1_q & CFG1_RD_MASK;
      SEL_CFG2: rd_mux = cfg2_q;
      SEL_STAT: rd_mux = stat_q;
      SEL_INT:  rd_mux = int_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R12
  evt_survives_clear_chk: assert property (@(posedge clk) disable iff (rst || warm_rst)
    (we_int && evt_valid_i) |=> int_q[PEND_BIT]);
  // R1
  cold_init_chk: assert property (@(posedge clk)
    $past(rst) |-> (int_q == INT_COLD_INIT && stat_q == '0 && !cmd_strobe_o));
endmodule

// File: tb/flash_irq_regs_tb_top.sv
module flash_irq_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        warm_rst = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cmd_strobe_o;
  logic [15:0] cmd_code_o;
  logic        evt_valid_i = 1'b0;
  logic [1:0]  evt_cls_i = '0;
  logic        evt_cls_en_i = 1'b0;
  logic [3:0]  evt_err_i = '0;
  logic        irq_o, ready_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flash_irq_regs dut_i (
    .clk(clk), .rst(rst), .warm_rst(warm_rst),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmd_strobe_o(cmd_strobe_o), .cmd_code_o(cmd_code_o),
    .evt_valid_i(evt_valid_i), .evt_cls_i(evt_cls_i), .evt_cls_en_i(evt_cls_en_i),
    .evt_err_i(evt_err_i), .irq_o(irq_o), .ready_o(ready_o)
  );

  // op: 0 write, 1 read and compare, 2 engine event (data[1:0] class, [2] class enable, [6:3] errors)
  localparam int NV = 13;
  localparam logic [40:0] VEC [NV] = '{
    {4'd1,  2'd1, 3'd4, 16'h0000, 16'h8080}, // R1 interrupt after cold reset
    {4'd1,  2'd1, 3'd1, 16'h0000, 16'h40C0}, // R1 configuration-1
    {4'd3,  2'd0, 3'd1, 16'hFFFF, 16'h0000}, // R3 write all ones
    {4'd3,  2'd1, 3'd1, 16'h0000, 16'hFFE0}, // R3 masked readback
    {4'd6,  2'd0, 3'd4, 16'h7FFF, 16'h0000}, // R6 AND-write
    {4'd6,  2'd1, 3'd4, 16'h0000, 16'h0080}, // R6
    {4'd9,  2'd0, 3'd0, 16'h0094, 16'h0000}, // R9 accepted command
    {4'd9,  2'd1, 3'd0, 16'h0000, 16'h0094}, // R9
    {4'd10, 2'd2, 3'd0, 16'h0005, 16'h0000}, // R10 erase done
    {4'd10, 2'd1, 3'd4, 16'h0000, 16'h80A0}, // R10
    {4'd8,  2'd0, 3'd0, 16'h0080, 16'h0000}, // R8 refused command
    {4'd8,  2'd1, 3'd0, 16'h0000, 16'h0094}, // R8
    {4'd13, 2'd1, 3'd7, 16'h0000, 16'h0000}  // R13 unused offset
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a;
    @(negedge clk);
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic do_event(input logic [1:0] c, input logic en, input logic [3:0] e);
    evt_valid_i = 1'b1; evt_cls_i = c; evt_cls_en_i = en; evt_err_i = e;
    @(negedge clk);
    evt_valid_i = 1'b0; evt_cls_en_i = 1'b0; evt_err_i = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq_o", {15'd0, irq_o}, 16'h0001);
    chk("R1 ready_o", {15'd0, ready_o}, 16'h0001);
    chk("R1 strobe", {15'd0, cmd_strobe_o}, 16'h0000);
    do_read(3'd3, v); chk("R1 status", v, 16'h0000);
    do_read(3'd2, v); chk("R1 cfg2", v, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [2:0]  ad;
      logic [15:0] dt, ex;
      {rq, op, ad, dt, ex} = VEC[i];
      case (op)
        2'd0: do_write(ad, dt);
        2'd2: do_event(dt[1:0], dt[2], dt[6:3]);
        default: begin
          do_read(ad, v);
          chk($sformatf("R%0d vector %0d", rq, i), v, ex);
        end
      endcase
    end

    // R11: program done with program error; interrupt now 0x80E0
    do_event(2'd2, 1'b1, 4'b0100);
    do_read(3'd3, v); chk("R11 status program error", v, 16'h1000);
    do_read(3'd4, v); chk("R11 interrupt", v, 16'h80E0);
    // R7: bit 15 kept, errors kept
    do_write(3'd4, 16'h8000);
    do_read(3'd3, v); chk("R7 status kept", v, 16'h1000);
    // R7: bit 15 cleared, errors wiped
    do_write(3'd4, 16'h0000);
    do_read(3'd3, v); chk("R7 status wiped", v, 16'h0000);

    // R9: strobe one cycle with code
    do_write(3'd0, 16'h0013);
    chk("R9 strobe high", {15'd0, cmd_strobe_o}, 16'h0001);
    chk("R9 code", cmd_code_o, 16'h0013);
    @(negedge clk);
    chk("R9 strobe low", {15'd0, cmd_strobe_o}, 16'h0000);

    // R5: cfg1 0xFFFF, pending 0 -> irq 0; flip polarity
    chk("R5 irq before", {15'd0, irq_o}, 16'h0000);
    do_write(3'd1, 16'h0080);
    chk("R5 irq lag", {15'd0, irq_o}, 16'h0000);
    chk("R4 ready set", {15'd0, ready_o}, 16'h0001);
    @(negedge clk);
    chk("R5 irq after", {15'd0, irq_o}, 16'h0001);
    do_write(3'd1, 16'h0040);
    chk("R4 ready cleared", {15'd0, ready_o}, 16'h0000);

    // R12: interrupt clear and load-done with load error in one cycle
    evt_valid_i = 1'b1; evt_cls_i = 2'd3; evt_cls_en_i = 1'b1; evt_err_i = 4'b1000;
    do_write(3'd4, 16'h0000);
    evt_valid_i = 1'b0; evt_cls_en_i = 1'b0; evt_err_i = '0;
    do_read(3'd4, v); chk("R12 interrupt", v, 16'h8080);
    do_read(3'd3, v); chk("R12 status", v, 16'h2000);

    // R8: pending set, command write refused
    do_write(3'd0, 16'h0071);
    chk("R8 no strobe", {15'd0, cmd_strobe_o}, 16'h0000);
    do_read(3'd0, v); chk("R8 command kept", v, 16'h0013);

    // R11: unknown command report
    do_write(3'd4, 16'h0000);
    do_event(2'd0, 1'b0, 4'b0001);
    do_read(3'd4, v); chk("R11 unknown interrupt", v, 16'h8000);
    do_read(3'd3, v); chk("R11 unknown status", v, 16'h0400);

    // R2: warm reset
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    chk("R2 ready", {15'd0, ready_o}, 16'h0001);
    do_read(3'd4, v); chk("R2 interrupt", v, 16'h8010);
    do_read(3'd1, v); chk("R2 cfg1", v, 16'h40C0);
    do_read(3'd3, v); chk("R2 status", v, 16'h0000);
    do_read(3'd0, v); chk("R2 command", v, 16'h0000);
    chk("R2 irq", {15'd0, irq_o}, 16'h0001);

    finish_run();
  end
endmodule